// File: doc/BRIEF.md
# Multi-cycle 32-bit RISC core

This block is a small, non-pipelined 32-bit processor built around one state machine. It owns a word-addressed external bus. The bus has a 32-bit address, a data path that is split into an input word and an output word with an output-enable bit, and three active-low strobes for read, write and halted. Memory and peripherals sample the bus on the falling clock edge. The core changes every output on the rising edge, so a slave always sees stable signals half a cycle before it acts.

Each instruction passes through the same sequence of states. ST_RESET is entered asynchronously when `rst_n` is low. It clears the PC and the register file and then moves to ST_FETCH0. ST_FETCH0 puts the PC on the address bus, pulls `rd_n` low and moves to ST_FETCH1. ST_FETCH1 captures the returned word into the instruction register, releases `rd_n` and moves to ST_EXEC in phase 0. In ST_EXEC phase 0, ALU, move, branch, jump and NOP instructions complete and return to ST_FETCH0. A load or store instead moves to ST_EXEC phase 1, which completes the transfer, floats the buses and returns to ST_FETCH0. A halt instruction moves to ST_HALT, which holds until the next reset.

Top module: `rcpu_core`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls, `rd_n`, `wr_n` and `halt_n` are 1 and both output enables are 0. After release, the first rising edge keeps the bus idle (ST_RESET). The second rising edge starts a fetch from address 0.
- R2: A fetch drives the PC on `bus_addr` with `bus_addr_oe`=1 and holds `rd_n` low for exactly one cycle. The word on `bus_din` at the next rising edge becomes the instruction. The PC advances by one word for each instruction that does not transfer control.
- R3: The instruction word carries the opcode in bits 31..26 and the source register A in 25..21. Register B or the I-type destination is in 20..16. The R-type destination is in 15..11, and the immediate is in 15..0.
- R4: Opcode 010001 copies register A to B. Opcode 010010 writes A+B to the R-type destination. Opcode 010011 writes A−B to the R-type destination. All results are modulo 2^32.
- R5: Opcode 001000 writes A+imm, 001001 writes A−imm and 001100 writes A AND imm to register B. The immediate is zero-extended.
- R6: Register 0 always reads as zero. A write aimed at register 0 changes nothing.
- R7: Opcode 000010 continues execution at the zero-extended value of bits 25..0.
- R8: Opcode 000100 (taken when A equals B) and opcode 000101 (taken when A differs from B) continue at the zero-extended 16-bit immediate. When not taken, execution continues at PC+1.
- R9: Opcode 101011 stores register B to address A+imm. It drives the address and data with both enables at 1 and holds `wr_n` low for one cycle. On the next cycle it releases `wr_n` and clears both enables.
- R10: Opcode 100011 pulls `rd_n` low for one cycle with address A+imm. It writes the word returned on `bus_din` into register B.
- R11: Opcode 111111 drives `halt_n` low. From then until reset there is no further read or write strobe.
- R12: Any other opcode behaves as a NOP: it changes no register and execution goes on at PC+1.
- R13: The register file holds 8 registers. Each 5-bit register field selects a register by its low 3 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the core acts on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | output | 32 | Word address |
| bus_addr_oe | output | 1 | 1 while the core drives the address |
| bus_din | input | 32 | Read data returned by the slave |
| bus_dout | output | 32 | Write data |
| bus_dout_oe | output | 1 | 1 while the core drives the data bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| halt_n | output | 1 | Halted flag, active low |

## Verification
Register contents are visible only through stores, so each program ends its computation with a store of every result. A wrong register, a wrong ALU path or a bad index appears as a wrong word at the next write strobe, a few cycles after the faulty instruction. A wrong PC or branch decision shows up as the wrong stored marker or a missing store. It can also appear as an early halt, because unused program words hold HALT. A bad sequencer state shows up within one cycle as a strobe that is too long, a data enable left on, or bus activity after `halt_n` falls.

// File: rtl/rcpu_pkg.sv
package rcpu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_NOP  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_MOV  = 6'b010001;
    localparam logic [OPC_W-1:0] OPC_ADD  = 6'b010010;
    localparam logic [OPC_W-1:0] OPC_SUB  = 6'b010011;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_SUBI = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_LW   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW   = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_HALT = 6'b111111;

    // sequencer states
    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH0,
        ST_FETCH1,
        ST_EXEC,
        ST_HALT
    } cpu_state_t;

    // decoded operation class
    typedef enum logic [3:0] {
        K_NOP,
        K_MOV,
        K_ADD,
        K_SUB,
        K_ADDI,
        K_SUBI,
        K_ANDI,
        K_BEQ,
        K_BNE,
        K_JMP,
        K_LW,
        K_SW,
        K_HALT
    } op_kind_t;

endpackage

// File: rtl/rcpu_decode.sv
module rcpu_decode
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RIDX = 3
) (
    input  logic [31:0]     instr,
    output op_kind_t        kind,
    output logic [RIDX-1:0] ra_idx,
    output logic [RIDX-1:0] rb_idx,
    output logic [RIDX-1:0] rd_idx,
    output logic [XLEN-1:0] imm_zx,
    output logic [XLEN-1:0] jmp_tgt
);

    // register fields: only the low RIDX bits select a register
    assign ra_idx  = instr[21 +: RIDX];
    assign rb_idx  = instr[16 +: RIDX];
    assign rd_idx  = instr[11 +: RIDX];
    assign imm_zx  = XLEN'(instr[15:0]);
    assign jmp_tgt = XLEN'(instr[25:0]);

    always_comb begin
        case (instr[31:26])
            OPC_MOV:  kind = K_MOV;
            OPC_ADD:  kind = K_ADD;
            OPC_SUB:  kind = K_SUB;
            OPC_ADDI: kind = K_ADDI;
            OPC_SUBI: kind = K_SUBI;
            OPC_ANDI: kind = K_ANDI;
            OPC_BEQ:  kind = K_BEQ;
            OPC_BNE:  kind = K_BNE;
            OPC_JMP:  kind = K_JMP;
            OPC_LW:   kind = K_LW;
            OPC_SW:   kind = K_SW;
            OPC_HALT: kind = K_HALT;
            default:  kind = K_NOP;   // NOP and every undefined code
        endcase
    end

endmodule

// File: rtl/rcpu_regfile.sv
module rcpu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [RIDX-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RIDX-1:0] raddr_a,
    input  logic [RIDX-1:0] raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);

    // entry 0 is not stored: it reads as zero and drops writes
    logic [XLEN-1:0] regs [1:NREG-1];

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (clr) begin
                regs[g] <= '0;
            end else if (we && waddr == RIDX'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 1; i < NREG; i++) begin
            if (raddr_a == RIDX'(i)) rdata_a = regs[i];
            if (raddr_b == RIDX'(i)) rdata_b = regs[i];
        end
    end

endmodule

// File: rtl/rcpu_alu.sv
module rcpu_alu
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_kind_t        kind,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] result,
    output logic            equal
);

    assign equal = (opa == opb);

    always_comb begin
        case (kind)
            K_MOV:   result = opa;
            K_ADD:   result = opa + opb;
            K_SUB:   result = opa - opb;
            K_ADDI:  result = opa + imm;
            K_SUBI:  result = opa - imm;
            K_ANDI:  result = opa & imm;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rcpu_core.sv
module rcpu_core
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] bus_addr,
    output logic            bus_addr_oe,
    input  logic [XLEN-1:0] bus_din,
    output logic [XLEN-1:0] bus_dout,
    output logic            bus_dout_oe,
    output logic            rd_n,
    output logic            wr_n,
    output logic            halt_n
);

    localparam int RIDX = $clog2(NREG);

    cpu_state_t      state, state_nx;
    logic            phase, phase_nx;     // 0: first execute cycle, 1: bus completion
    logic [XLEN-1:0] pc, pc_nx;
    logic [31:0]     ir;

    op_kind_t        kind;
    logic [RIDX-1:0] ra_idx, rb_idx, rd_idx;
    logic [XLEN-1:0] imm_zx, jmp_tgt;
    logic [XLEN-1:0] ra_val, rb_val, alu_res, mem_addr;
    logic            eq;

    logic            rf_we, rf_clr;
    logic [RIDX-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    logic            exec_first, exec_second, is_mem;

    rcpu_decode #(.XLEN(XLEN), .RIDX(RIDX)) u_dec (
        .instr  (ir),
        .kind   (kind),
        .ra_idx (ra_idx),
        .rb_idx (rb_idx),
        .rd_idx (rd_idx),
        .imm_zx (imm_zx),
        .jmp_tgt(jmp_tgt)
    );

    rcpu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rf_clr),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr_a(ra_idx),
        .raddr_b(rb_idx),
        .rdata_a(ra_val),
        .rdata_b(rb_val)
    );

    rcpu_alu #(.XLEN(XLEN)) u_alu (
        .kind  (kind),
        .opa   (ra_val),
        .opb   (rb_val),
        .imm   (imm_zx),
        .result(alu_res),
        .equal (eq)
    );

    assign mem_addr    = ra_val + imm_zx;
    assign exec_first  = (state == ST_EXEC) && !phase;
    assign exec_second = (state == ST_EXEC) && phase;
    assign is_mem      = (kind == K_LW) || (kind == K_SW);
    assign rf_clr      = (state == ST_RESET);

    // next-state logic
    always_comb begin
        state_nx = state;
        phase_nx = 1'b0;
        unique case (state)
            ST_RESET:  state_nx = ST_FETCH0;
            ST_FETCH0: state_nx = ST_FETCH1;
            ST_FETCH1: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (phase) begin
                    state_nx = ST_FETCH0;
                end else if (is_mem) begin
                    state_nx = ST_EXEC;
                    phase_nx = 1'b1;
                end else if (kind == K_HALT) begin
                    state_nx = ST_HALT;
                end else begin
                    state_nx = ST_FETCH0;
                end
            end
            ST_HALT:   state_nx = ST_HALT;
        endcase
    end

    // next program counter
    always_comb begin
        pc_nx = pc + XLEN'(1);
        case (kind)
            K_JMP:   pc_nx = jmp_tgt;
            K_BEQ:   if (eq)  pc_nx = imm_zx;
            K_BNE:   if (!eq) pc_nx = imm_zx;
            default: ;
        endcase
    end

    // register write port
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = rb_idx;
        rf_wdata = alu_res;
        if (exec_first) begin
            case (kind)
                K_MOV, K_ADDI, K_SUBI, K_ANDI: rf_we = 1'b1;
                K_ADD, K_SUB: begin
                    rf_we    = 1'b1;
                    rf_waddr = rd_idx;
                end
                default: ;
            endcase
        end else if (exec_second && kind == K_LW) begin
            rf_we    = 1'b1;
            rf_wdata = bus_din;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
            phase <= 1'b0;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (state == ST_RESET) pc <= '0;
            else if (exec_first)   pc <= pc_nx;
            if (state == ST_FETCH1) ir <= bus_din;
        end
    end

    // registered bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr    <= '0;
            bus_addr_oe <= 1'b0;
            bus_dout    <= '0;
            bus_dout_oe <= 1'b0;
            rd_n        <= 1'b1;
            wr_n        <= 1'b1;
            halt_n      <= 1'b1;
        end else begin
            unique case (state)
                ST_RESET: begin
                    bus_addr_oe <= 1'b0;
                    bus_dout_oe <= 1'b0;
                    rd_n        <= 1'b1;
                    wr_n        <= 1'b1;
                    halt_n      <= 1'b1;
                end
                ST_FETCH0: begin
                    bus_addr    <= pc;
                    bus_addr_oe <= 1'b1;
                    bus_dout_oe <= 1'b0;
                    rd_n        <= 1'b0;
                end
                ST_FETCH1: begin
                    rd_n <= 1'b1;
                end
                ST_EXEC: begin
                    if (!phase) begin
                        case (kind)
                            K_SW: begin
                                bus_addr    <= mem_addr;
                                bus_addr_oe <= 1'b1;
                                bus_dout    <= rb_val;
                                bus_dout_oe <= 1'b1;
                                wr_n        <= 1'b0;
                            end
                            K_LW: begin
                                bus_addr    <= mem_addr;
                                bus_addr_oe <= 1'b1;
                                rd_n        <= 1'b0;
                            end
                            K_HALT: halt_n <= 1'b0;
                            default: ;
                        endcase
                    end else begin
                        bus_addr_oe <= 1'b0;
                        bus_dout_oe <= 1'b0;
                        rd_n        <= 1'b1;
                        wr_n        <= 1'b1;
                    end
                end
                ST_HALT: begin
                    halt_n <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rcpu_core_chk.sv
module rcpu_core_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_addr_oe,
    input logic bus_dout_oe,
    input logic rd_n,
    input logic wr_n,
    input logic halt_n
);

    // R1: reset forces an idle bus
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (rd_n && wr_n && halt_n && !bus_addr_oe && !bus_dout_oe)
                else $error("bus not idle during reset");
        end
    end

    // R2 / R10: a read strobe lasts exactly one cycle
    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);

    // R9: a write strobe lasts one cycle and the buses are released afterwards
    assert_write_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_n && !bus_dout_oe && !bus_addr_oe));

    // R9: data and address are driven while writing
    assert_write_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (bus_dout_oe && bus_addr_oe));

    // R9 / R10: never read and write together
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R11: halt is sticky and silences the bus
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> (!halt_n && rd_n && wr_n));

endmodule

bind rcpu_core rcpu_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr_oe(bus_addr_oe),
    .bus_dout_oe(bus_dout_oe),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .halt_n     (halt_n)
);

// File: tb/rcpu_core_test.sv
`timescale 1ns/1ps
module rcpu_core_test;

    localparam logic [5:0] O_MOV  = 6'b010001, O_ADD  = 6'b010010, O_SUB  = 6'b010011;
    localparam logic [5:0] O_ADDI = 6'b001000, O_SUBI = 6'b001001, O_ANDI = 6'b001100;
    localparam logic [5:0] O_BEQ  = 6'b000100, O_BNE  = 6'b000101, O_JMP  = 6'b000010;
    localparam logic [5:0] O_LW   = 6'b100011, O_SW   = 6'b101011, O_HALT = 6'b111111;
    localparam logic [31:0] W_HALT = {O_HALT, 26'd0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr, bus_din, bus_dout;
    logic        bus_addr_oe, bus_dout_oe, rd_n, wr_n, halt_n;

    always #2.5 clk = ~clk;

    rcpu_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_addr_oe(bus_addr_oe),
        .bus_din    (bus_din),
        .bus_dout   (bus_dout),
        .bus_dout_oe(bus_dout_oe),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .halt_n     (halt_n)
    );

    logic [31:0] mem [0:1023];          // written only by the stimulus process
    logic [31:0] wlog_a [0:1023];
    logic [31:0] wlog_d [0:1023];
    int          wlog_n = 0;
    int          err_rd_long = 0, err_wr_float = 0;
    logic        prev_rd_low = 1'b0, prev_wr_low = 1'b0;
    int          n_chk = 0, n_fail = 0;

    // behavioural slave: acts on the falling edge
    always @(negedge clk) begin
        if (!rd_n) bus_din <= mem[bus_addr[9:0]];
        else       bus_din <= 32'hDEAD_BEEF;
        if (!wr_n) begin
            wlog_a[wlog_n % 1024] <= bus_addr;
            wlog_d[wlog_n % 1024] <= bus_dout;
            wlog_n <= wlog_n + 1;
        end
        if (rst_n && !rd_n && prev_rd_low) err_rd_long <= err_rd_long + 1;
        if (rst_n && prev_wr_low && (bus_dout_oe || bus_addr_oe || !wr_n)) err_wr_float <= err_wr_float + 1;
        prev_rd_low <= rst_n && !rd_n;
        prev_wr_low <= rst_n && !wr_n;
    end

    function automatic logic [31:0] enc_r(logic [5:0] op, int a, int b, int d);
        return {op, 5'(a), 5'(b), 5'(d), 11'd0};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int a, int b, logic [15:0] imm);
        return {op, 5'(a), 5'(b), imm};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    endtask

    // reset, run to halt and check sequencing; returns log base index
    task automatic run_prog(output int base);
        int rd0, wr0, cyc;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_n && wr_n && halt_n && !bus_addr_oe && !bus_dout_oe, "R1 reset idle",
            {27'd0, rd_n, wr_n, halt_n, bus_addr_oe, bus_dout_oe}, 32'h1C);
        base = wlog_n;
        rd0 = err_rd_long;
        wr0 = err_wr_float;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n == 1'b1, "R1 reset state idle", {31'd0, rd_n}, 32'd1);
        @(negedge clk);
        chk(!rd_n && bus_addr_oe && bus_addr == 32'd0, "R2 first fetch at 0", bus_addr, 32'd0);
        cyc = 0;
        while (halt_n && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!halt_n, "R11 reached halt", {31'd0, halt_n}, 32'd0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!halt_n && rd_n && wr_n, "R11 silent after halt",
                {29'd0, halt_n, rd_n, wr_n}, 32'd3);
        end
        chk(err_rd_long == rd0, "R2 read strobe one cycle", 32'(err_rd_long - rd0), 32'd0);
        chk(err_wr_float == wr0, "R9 release after write", 32'(err_wr_float - wr0), 32'd0);
        // asynchronous reset from the halted state
        #1 rst_n = 1'b0;
        #0.5;
        chk(halt_n && rd_n && wr_n && !bus_addr_oe, "R1 async reset",
            {29'd0, halt_n, rd_n, wr_n}, 32'd7);
    endtask

    task automatic chk_store(input int base, input int idx, input logic [31:0] ea,
                             input logic [31:0] ed, input string req);
        chk(wlog_a[(base + idx) % 1024] == ea, {req, " addr"}, wlog_a[(base + idx) % 1024], ea);
        chk(wlog_d[(base + idx) % 1024] == ed, {req, " data"}, wlog_d[(base + idx) % 1024], ed);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin : stim
        logic [31:0] vals [8];
        int base;
        vals = '{32'd0, 32'd1, 32'd5, 32'h0000_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_8001};

        // sweep: ALU, immediates, move, branches, load and store (R3..R5, R8..R10)
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a, b, im;
                a  = vals[i];
                b  = vals[j];
                im = {16'd0, b[15:0]};
                clear_mem();
                mem[0]  = enc_i(O_LW, 0, 1, 16'h0100);
                mem[1]  = enc_i(O_LW, 0, 2, 16'h0101);
                mem[2]  = enc_r(O_ADD, 1, 2, 3);
                mem[3]  = enc_r(O_SUB, 1, 2, 4);
                mem[4]  = enc_i(O_SW, 0, 3, 16'h0200);
                mem[5]  = enc_i(O_SW, 0, 4, 16'h0201);
                mem[6]  = enc_i(O_ADDI, 1, 3, b[15:0]);
                mem[7]  = enc_i(O_SUBI, 1, 4, b[15:0]);
                mem[8]  = enc_i(O_ANDI, 1, 5, b[15:0]);
                mem[9]  = enc_i(O_SW, 0, 3, 16'h0202);
                mem[10] = enc_i(O_SW, 0, 4, 16'h0203);
                mem[11] = enc_i(O_SW, 0, 5, 16'h0204);
                mem[12] = enc_r(O_MOV, 1, 6, 0);
                mem[13] = enc_i(O_SW, 0, 6, 16'h0205);
                mem[14] = enc_i(O_BEQ, 1, 2, 16'd17);
                mem[15] = enc_i(O_ADDI, 0, 7, 16'd1);
                mem[16] = {O_JMP, 26'd18};
                mem[17] = enc_i(O_ADDI, 0, 7, 16'd2);
                mem[18] = enc_i(O_SW, 0, 7, 16'h0206);
                mem[19] = enc_i(O_BNE, 1, 2, 16'd22);
                mem[20] = enc_i(O_ADDI, 0, 7, 16'd3);
                mem[21] = {O_JMP, 26'd23};
                mem[22] = enc_i(O_ADDI, 0, 7, 16'd4);
                mem[23] = enc_i(O_SW, 0, 7, 16'h0207);
                mem[24] = W_HALT;
                mem[256] = a;
                mem[257] = b;
                run_prog(base);
                chk(wlog_n - base == 8, "R9 store count", 32'(wlog_n - base), 32'd8);
                chk_store(base, 0, 32'h200, a + b, "R4 add");
                chk_store(base, 1, 32'h201, a - b, "R4 sub");
                chk_store(base, 2, 32'h202, a + im, "R5 addi");
                chk_store(base, 3, 32'h203, a - im, "R5 subi");
                chk_store(base, 4, 32'h204, a & im, "R5 andi");
                chk_store(base, 5, 32'h205, a, "R4 mov / R10 load");
                chk_store(base, 6, 32'h206, (a == b) ? 32'd2 : 32'd1, "R8 beq");
                chk_store(base, 7, 32'h207, (a != b) ? 32'd4 : 32'd3, "R8 bne");
            end
        end

        // directed: register 0, index folding, undefined opcode, jump, offset load (R6, R7, R10, R12, R13)
        clear_mem();
        mem[0]  = 32'd0;
        mem[1]  = enc_i(O_ADDI, 0, 0, 16'd5);
        mem[2]  = enc_i(O_SW, 0, 0, 16'h0210);
        mem[3]  = enc_i(O_ADDI, 0, 9, 16'h0077);
        mem[4]  = enc_r(O_MOV, 1, 0, 0);
        mem[5]  = enc_i(O_SW, 0, 0, 16'h0211);
        mem[6]  = enc_i(O_SW, 0, 1, 16'h0212);
        mem[7]  = 32'hF8FF_FFFF;
        mem[8]  = enc_i(O_SW, 0, 9, 16'h0213);
        mem[9]  = {O_JMP, 26'd40};
        for (int k = 10; k < 40; k++) mem[k] = W_HALT;
        mem[40] = enc_i(O_ADDI, 0, 2, 16'h00F0);
        mem[41] = enc_i(O_LW, 2, 3, 16'h0010);
        mem[42] = enc_i(O_SW, 2, 3, 16'h0125);
        mem[43] = enc_i(O_SW, 0, 1, 16'h0214);
        mem[44] = W_HALT;
        mem[256] = 32'hCAFE_F00D;
        run_prog(base);
        chk(wlog_n - base == 6, "R7 store count after jump", 32'(wlog_n - base), 32'd6);
        chk_store(base, 0, 32'h210, 32'd0, "R6 write to r0 dropped");
        chk_store(base, 1, 32'h211, 32'd0, "R6 move to r0 dropped");
        chk_store(base, 2, 32'h212, 32'h77, "R13 field 9 selects r1");
        chk_store(base, 3, 32'h213, 32'h77, "R12 undefined opcode is nop");
        chk_store(base, 4, 32'h215, 32'hCAFE_F00D, "R10 load with base offset");
        chk_store(base, 5, 32'h214, 32'h77, "R7 jump target");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule